// File: doc/BRIEF.md
# Pixel Colour Conversion Matrix

This block turns a stream of RGB pixels into three new colour channels with a programmable 3x3 matrix. Each 12-bit input component first has a per-channel pre-offset taken away from it. The three results are multiplied by the coefficients of each output row and summed. A per-row post-offset is then added, the total is rounded to the nearest integer, and it is clamped to the 12-bit output range. The usual setting is RGB to YCbCr output: zero pre-offsets, a luma post-offset of 0x100 and chroma post-offsets of 0x800.

Coefficients are kept in a compact 16-bit pseudo-float made of a sign, an exponent code and a 9-bit mantissa. Software writes them, two to a 32-bit word, into a shadow register set through a simple write port. The shadow set is copied to the working set only on a frame-start pulse, so the settings never change partway through a frame. A placement bit for the conversion is held the same way and presented on an output. The datapath is a three-stage pipeline with a valid flag and no stall.

Top module: `ccm_top`

## Requirements
- R1: `outValid` is low after reset and equals `inValid` delayed by exactly three clock cycles. The output channels change only in a cycle where `outValid` is high.
- R2: Output channel k equals round(Ck0*(R-p0) + Ck1*(G-p1) + Ck2*(B-p2) + q_k), where p are the pre-offsets, q the post-offsets and Ckj the decoded coefficients. Coefficient bits 14:12 hold an exponent code and bits 11:3 a mantissa m. The magnitude is m/2^12 for code 3, m/2^11 for code 2, m/2^10 for code 1, m/2^9 for code 0, m/2^8 for code 7 and m/2^7 for code 6.
- R3: Coefficient bit 15 set makes the coefficient negative, with the same magnitude (sign-magnitude form).
- R4: Exponent codes 4 and 5 decode to a zero coefficient. Coefficient bits 2:0 have no effect.
- R5: The pre-offset of each input channel is subtracted from it before the multiply, and negative differences are kept signed.
- R6: The post-offset of each output row is added before rounding. Rounding is to the nearest integer, with an exact half rounded toward plus infinity.
- R7: Each result is clamped to 0..4095.
- R8: Register writes land in a shadow set. The working set, and so the results, take the shadow values only at a clock edge where `frameStart` is high. A write in the same cycle as `frameStart` is held until the next frame start. After reset all working and shadow values are zero.
- R9: Write address 2k (k = 0,1,2) loads output row k: R coefficient from data bits 31:16, G coefficient from bits 15:0. Address 2k+1 loads the row's B coefficient from bits 31:16, and bits 15:0 of that word are ignored.
- R10: Addresses 6, 7, 8 load the R, G, B pre-offsets and 9, 10, 11 the post-offsets of rows 0, 1, 2, each from data bits 11:0. Address 12 bit 0 loads the placement bit, seen on `cscAfterGamma` after the next frame start; 0 means before gamma.
- R11: Writes to addresses 13 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| frameStart | input | 1 | Commits shadow registers to the working set |
| inValid | input | 1 | Input pixel valid |
| inR | input | 12 | Input red component |
| inG | input | 12 | Input green component |
| inB | input | 12 | Input blue component |
| outValid | output | 1 | Output pixel valid |
| outC0 | output | 12 | Output row 0 result |
| outC1 | output | 12 | Output row 1 result |
| outC2 | output | 12 | Output row 2 result |
| cscAfterGamma | output | 1 | Working placement bit |

## Verification
A broken valid chain shows up in the first pixel as an output flag that is three cycles early or late. A wrong exponent shift or sign decode gives a result off by a power of two, or mirrored about the post-offset, in the cycle that pixel leaves the pipe. A shadow set that leaks early into the working set changes results before the frame-start pulse, and the next pixel shows it. Saturation and rounding faults appear only at extreme or half-way inputs, so the bench drives those patterns on purpose.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int PIX_W   = 12;
  localparam int NCH     = 3;
  localparam int FRAC_W  = 12;
  localparam int MANT_W  = 9;
  localparam int EXP_W   = 3;
  localparam int CODE_W  = 1 + EXP_W + MANT_W;
  localparam int MAXSH   = 5;
  localparam int MAG_W   = MANT_W + MAXSH;
  localparam int SC_W    = MAG_W + 1;
  localparam int DIFF_W  = PIX_W + 1;
  localparam int PROD_W  = DIFF_W + SC_W;
  localparam int ACC_W   = PROD_W + 3;
  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;
  localparam int HALF_W  = REG_DW / 2;
  localparam int ADDR_PRE  = 2 * NCH;
  localparam int ADDR_POST = ADDR_PRE + NCH;
  localparam int ADDR_MODE = ADDR_POST + NCH;

  typedef logic [CODE_W-1:0] coefCode_t;

  typedef struct packed {
    coefCode_t [NCH-1:0][NCH-1:0] coef;
    logic [NCH-1:0][PIX_W-1:0]    preOff;
    logic [NCH-1:0][PIX_W-1:0]    postOff;
  } ccmCfg_t;

  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } ccmStb_t;
endpackage

// File: rtl/ccm_ctrl.sv
module ccm_ctrl
  import ccm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [REG_DW-1:0]   regWdata,
  input  logic                frameStart,
  input  logic                inValid,
  output ccmCfg_t             cfgAct,
  output logic                modeAct,
  output ccmStb_t             stb,
  output logic                outValid
);
  ccmCfg_t cfgShd;
  logic    modeShd;
  logic    vS1, vS2;
  logic    unusedWdata;

  assign unusedWdata = ^regWdata[REG_DW-CODE_W-1:HALF_W];

  // shadow set written by software
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgShd  <= '0;
      modeShd <= 1'b0;
    end else if (regWe) begin
      for (int r = 0; r < NCH; r++) begin
        if (regAddr == REG_AW'(2 * r)) begin
          cfgShd.coef[r][0] <= regWdata[REG_DW-1 -: CODE_W];
          cfgShd.coef[r][1] <= regWdata[HALF_W-1 -: CODE_W];
        end
        if (regAddr == REG_AW'(2 * r + 1))
          cfgShd.coef[r][2] <= regWdata[REG_DW-1 -: CODE_W];
      end
      for (int c = 0; c < NCH; c++) begin
        if (regAddr == REG_AW'(ADDR_PRE + c))
          cfgShd.preOff[c] <= regWdata[PIX_W-1:0];
        if (regAddr == REG_AW'(ADDR_POST + c))
          cfgShd.postOff[c] <= regWdata[PIX_W-1:0];
      end
      if (regAddr == REG_AW'(ADDR_MODE))
        modeShd <= regWdata[0];
    end
  end

  // working set, committed on frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAct  <= '0;
      modeAct <= 1'b0;
    end else if (frameStart) begin
      cfgAct  <= cfgShd;
      modeAct <= modeShd;
    end
  end

  // valid chain that steers the datapath stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vS1      <= 1'b0;
      vS2      <= 1'b0;
      outValid <= 1'b0;
    end else begin
      vS1      <= inValid;
      vS2      <= vS1;
      outValid <= vS2;
    end
  end

  always_comb begin
    stb.s1En = inValid;
    stb.s2En = vS1;
    stb.s3En = vS2;
  end
endmodule

// File: rtl/ccm_datapath.sv
module ccm_datapath
  import ccm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ccmStb_t                   stb,
  input  ccmCfg_t                   cfg,
  input  logic [NCH-1:0][PIX_W-1:0] pixIn,
  output logic [NCH-1:0][PIX_W-1:0] pixOut
);
  localparam int OUT_MAX = (1 << PIX_W) - 1;
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'(OUT_MAX);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W - 1);

  logic signed [DIFF_W-1:0] diffQ  [NCH];
  logic signed [SC_W-1:0]   coefS  [NCH][NCH];
  logic signed [PROD_W-1:0] prodQ  [NCH][NCH];

  // stage 1: remove pre-offsets
  for (genvar c = 0; c < NCH; c++) begin : gPre
    always_ff @(posedge clk) begin
      if (!rstN)
        diffQ[c] <= '0;
      else if (stb.s1En)
        diffQ[c] <= $signed({1'b0, pixIn[c]}) - $signed({1'b0, cfg.preOff[c]});
    end
  end

  // coefficient decode and stage 2 products
  for (genvar r = 0; r < NCH; r++) begin : gRow
    for (genvar c = 0; c < NCH; c++) begin : gCol
      logic [EXP_W-1:0]  expCode;
      logic [MANT_W-1:0] mant;
      logic              neg;
      logic [MAG_W-1:0]  magU;
      logic              unusedLow;

      assign neg     = cfg.coef[r][c][CODE_W-1];
      assign expCode = cfg.coef[r][c][CODE_W-2 -: EXP_W];
      assign mant    = cfg.coef[r][c][MANT_W-1:0];
      assign unusedLow = 1'b0;

      always_comb begin
        case (expCode)
          3'd3:    magU = MAG_W'(mant);
          3'd2:    magU = MAG_W'(mant) << 1;
          3'd1:    magU = MAG_W'(mant) << 2;
          3'd0:    magU = MAG_W'(mant) << 3;
          3'd7:    magU = MAG_W'(mant) << 4;
          3'd6:    magU = MAG_W'(mant) << 5;
          default: magU = '0;
        endcase
        coefS[r][c] = neg ? -$signed({1'b0, magU}) : $signed({1'b0, magU});
      end

      always_ff @(posedge clk) begin
        if (!rstN)
          prodQ[r][c] <= '0;
        else if (stb.s2En)
          prodQ[r][c] <= diffQ[c] * coefS[r][c];
      end
    end

    // stage 3: sum, post-offset, round, clamp
    logic signed [ACC_W-1:0] accS;
    logic signed [ACC_W-1:0] intS;
    logic [PIX_W-1:0]        satV;

    always_comb begin
      accS = (ACC_W'($signed({1'b0, cfg.postOff[r]})) <<< FRAC_W) + HALF_LSB;
      for (int c = 0; c < NCH; c++)
        accS = accS + ACC_W'(prodQ[r][c]);
      intS = accS >>> FRAC_W;
      if (intS < 0)
        satV = '0;
      else if (intS > MAX_S)
        satV = PIX_W'(OUT_MAX);
      else
        satV = intS[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        pixOut[r] <= '0;
      else if (stb.s3En)
        pixOut[r] <= satV;
    end
  end
endmodule

// File: rtl/ccm_top.sv
module ccm_top
  import ccm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  input  logic              frameStart,
  input  logic              inValid,
  input  logic [PIX_W-1:0]  inR,
  input  logic [PIX_W-1:0]  inG,
  input  logic [PIX_W-1:0]  inB,
  output logic              outValid,
  output logic [PIX_W-1:0]  outC0,
  output logic [PIX_W-1:0]  outC1,
  output logic [PIX_W-1:0]  outC2,
  output logic              cscAfterGamma
);
  ccmCfg_t                   cfgAct;
  ccmStb_t                   stb;
  logic [NCH-1:0][PIX_W-1:0] pixIn;
  logic [NCH-1:0][PIX_W-1:0] pixOut;

  assign pixIn[0] = inR;
  assign pixIn[1] = inG;
  assign pixIn[2] = inB;
  assign outC0 = pixOut[0];
  assign outC1 = pixOut[1];
  assign outC2 = pixOut[2];

  ccm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .frameStart (frameStart),
    .inValid    (inValid),
    .cfgAct     (cfgAct),
    .modeAct    (cscAfterGamma),
    .stb        (stb),
    .outValid   (outValid)
  );

  ccm_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cfg    (cfgAct),
    .pixIn  (pixIn),
    .pixOut (pixOut)
  );
endmodule

// File: rtl/ccm_chk.sv
module ccm_chk
  import ccm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic             inValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outC0,
  input logic [PIX_W-1:0] outC1,
  input logic [PIX_W-1:0] outC2,
  input logic             cscAfterGamma,
  input ccmCfg_t          cfgAct
);
  logic [1:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rstN)
      sinceRst <= '0;
    else if (sinceRst != 2'd3)
      sinceRst <= sinceRst + 2'd1;
  end
  assign warm = (sinceRst == 2'd3);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, 3)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !outValid) |-> ($stable(outC0) && $stable(outC1) && $stable(outC2)));

  assert_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(frameStart)) |-> $stable(cfgAct));

  assert_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$stable(cscAfterGamma)) |-> $past(frameStart));
endmodule

bind ccm_top ccm_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .frameStart    (frameStart),
  .inValid       (inValid),
  .outValid      (outValid),
  .outC0         (outC0),
  .outC1         (outC1),
  .outC2         (outC2),
  .cscAfterGamma (cscAfterGamma),
  .cfgAct        (cfgAct)
);

// File: tb/sim_ccm_top.sv
`timescale 1ns/1ps
module sim_ccm_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        frameStart = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inR = '0, inG = '0, inB = '0;
  logic        outValid;
  logic [11:0] outC0, outC1, outC2;
  logic        cscAfterGamma;

  always #4 clk = ~clk;

  ccm_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .frameStart(frameStart), .inValid(inValid), .inR(inR), .inG(inG), .inB(inB),
    .outValid(outValid), .outC0(outC0), .outC1(outC1), .outC2(outC2),
    .cscAfterGamma(cscAfterGamma)
  );

  typedef struct {
    int     e[3];
    longint cyc;
    string  tag;
  } item_t;

  item_t  sbq[$];
  int     nChk = 0;
  int     nFail = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  // model of shadow and working register sets
  logic [15:0] sC[3][3], aC[3][3];
  int          sPre[3], aPre[3], sPost[3], aPost[3];
  bit          sMode, aMode;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint coefVal(logic [15:0] c);
    int f;
    longint v;
    case (c[14:12])
      3'd3: f = 12;
      3'd2: f = 11;
      3'd1: f = 10;
      3'd0: f = 9;
      3'd7: f = 8;
      3'd6: f = 7;
      default: return 0;
    endcase
    v = longint'(c[11:3]) << (12 - f);
    return c[15] ? -v : v;
  endfunction

  function automatic int rowOut(int row, int r, int g, int b);
    int     px[3];
    longint acc;
    px[0] = r; px[1] = g; px[2] = b;
    acc = (longint'(aPost[row]) << 12) + 2048;
    for (int k = 0; k < 3; k++)
      acc += coefVal(aC[row][k]) * longint'(px[k] - aPre[k]);
    acc = acc >>> 12;
    if (acc < 0) return 0;
    if (acc > 4095) return 4095;
    return int'(acc);
  endfunction

  function automatic logic [15:0] enc(bit s, int code, int mant, int junk);
    return {s, 3'(code), 9'(mant), 3'(junk)};
  endfunction

  task automatic modelWrite(int a, logic [31:0] d);
    for (int r = 0; r < 3; r++) begin
      if (a == 2 * r) begin sC[r][0] = d[31:16]; sC[r][1] = d[15:0]; end
      if (a == 2 * r + 1) sC[r][2] = d[31:16];
    end
    if (a >= 6 && a <= 8) sPre[a - 6] = int'(d[11:0]);
    if (a >= 9 && a <= 11) sPost[a - 9] = int'(d[11:0]);
    if (a == 12) sMode = d[0];
  endtask

  task automatic commitModel();
    aC = sC; aPre = sPre; aPost = sPost; aMode = sMode;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'(a); regWdata = d;
    modelWrite(a, d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic drain();
    inValid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fs();
    drain();
    frameStart = 1'b1;
    commitModel();
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // write and frame start in the same cycle (R8)
  task automatic wrFs(int a, logic [31:0] d);
    drain();
    frameStart = 1'b1; regWe = 1'b1; regAddr = 4'(a); regWdata = d;
    commitModel();
    modelWrite(a, d);
    @(negedge clk);
    frameStart = 1'b0; regWe = 1'b0;
  endtask

  task automatic pix(int r, int g, int b, string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1; inR = 12'(r); inG = 12'(g); inB = 12'(b);
    for (int k = 0; k < 3; k++) it.e[k] = rowOut(k, r, g, b);
    it.cyc = cyc;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: compare results as they leave the design
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1", "unexpected outValid", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(cyc == it.cyc + 3, "R1", "latency", cyc - it.cyc, 3);
        chk(int'(outC0) == it.e[0], it.tag, "outC0", outC0, it.e[0]);
        chk(int'(outC1) == it.e[1], it.tag, "outC1", outC1, it.e[1]);
        chk(int'(outC2) == it.e[2], it.tag, "outC2", outC2, it.e[2]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", sbq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) begin sC[r][k] = '0; end
      sPre[r] = 0; sPost[r] = 0;
    end
    sMode = 1'b0;
    commitModel();

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R8 reset state
    chk(outValid == 1'b0, "R1", "reset outValid", outValid, 0);
    chk(outC0 == 0 && outC1 == 0 && outC2 == 0, "R8", "reset outputs", outC0, 0);
    chk(cscAfterGamma == 1'b0, "R10", "reset placement bit", cscAfterGamma, 0);

    // zero matrix gives zero output
    pix(100, 200, 300, "R8");
    idle(1);

    // identity in shadow only: no effect before frame start (R8)
    wr(0, {enc(0, 7, 256, 0), 16'h0000});
    wr(2, {16'h0000, enc(0, 7, 256, 0)});
    wr(5, {enc(0, 7, 256, 0), 16'h0000});
    pix(111, 222, 333, "R8");
    idle(1);
    fs();
    // R9 identity, back to back pixels
    pix(0, 0, 0, "R9");
    pix(4095, 1, 2048, "R9");
    pix(17, 4000, 5, "R9");
    idle(2);

    // R4 mantissa low bits ignored, B lower half ignored (R9)
    wr(0, {enc(0, 7, 256, 7), enc(0, 3, 0, 5)});
    wr(5, {enc(0, 7, 256, 3), 16'hFFFF});
    fs();
    pix(1234, 567, 890, "R4");
    idle(1);

    // R5 pre-offsets
    wr(6, 32'hFFFF_F100);
    wr(7, 32'h0000_0200);
    wr(8, 32'h0000_0300);
    fs();
    pix(16'h50, 16'h800, 16'hFFF, "R5");
    pix(16'h100, 16'h200, 16'h300, "R5");
    idle(1);
    wr(6, 0); wr(7, 0); wr(8, 0);

    // R2 / R6 RGB to YCbCr style matrix with signed coefficients (R3)
    wr(0, {enc(0, 1, 256, 0), enc(1, 1, 460, 0)});   // row0: 0.25, -0.449
    wr(1, {enc(1, 3, 330, 0), 16'h0000});            // row0 B: -0.0806
    wr(2, {enc(0, 2, 435, 0), enc(0, 0, 366, 0)});   // row1 luma
    wr(3, {enc(0, 3, 295, 0), 16'h0000});
    wr(4, {enc(1, 3, 470, 0), enc(1, 1, 395, 0)});   // row2 chroma
    wr(5, {enc(0, 0, 256, 0), 16'h0000});
    wr(9, 32'h800); wr(10, 32'h100); wr(11, 32'h800);
    fs();
    seed = 7;
    for (int i = 0; i < 40; i++) begin
      int r, g, b;
      seed = seed * 1103515245 + 12345; r = (seed >>> 8) & 12'hFFF;
      seed = seed * 1103515245 + 12345; g = (seed >>> 8) & 12'hFFF;
      seed = seed * 1103515245 + 12345; b = (seed >>> 8) & 12'hFFF;
      pix(r, g, b, "R2");
      if ((seed & 3) == 0) idle(1 + ((seed >>> 4) & 3));
    end
    pix(4095, 4095, 4095, "R3");
    pix(4095, 0, 0, "R3");
    idle(1);

    // R4 reserved exponent codes give zero
    wr(0, {enc(0, 4, 511, 0), enc(0, 5, 511, 0)});
    wr(1, {enc(1, 4, 300, 0), 16'h0000});
    fs();
    pix(4095, 4095, 4095, "R4");
    idle(1);

    // R6 rounding of exact halves
    wr(0, {enc(0, 0, 256, 0), 16'h0000});            // +0.5
    wr(1, 0);
    wr(2, {enc(1, 0, 256, 0), 16'h0000});            // -0.5
    wr(3, 0);
    wr(4, {enc(0, 3, 1, 0), 16'h0000});              // 1/4096
    wr(5, 0);
    wr(9, 0); wr(10, 32'h100); wr(11, 0);
    fs();
    pix(1, 0, 0, "R6");
    pix(3, 0, 0, "R6");
    pix(2048, 0, 0, "R6");
    pix(2047, 0, 0, "R6");
    idle(1);

    // R7 saturation both ways, largest scaling code 6
    wr(0, {enc(0, 6, 511, 0), 16'h0000});
    wr(2, {16'h0000, enc(1, 6, 511, 0)});
    wr(5, {enc(0, 6, 511, 0), 16'h0000});
    wr(11, 32'h800);
    fs();
    pix(4095, 4095, 1, "R7");
    pix(1000, 0, 0, "R7");
    idle(1);

    // R10 placement bit only after frame start
    wr(12, 32'h1);
    @(negedge clk);
    chk(cscAfterGamma == 1'b0, "R10", "placement before commit", cscAfterGamma, 0);
    fs();
    chk(cscAfterGamma == 1'b1, "R10", "placement after commit", cscAfterGamma, 1);

    // R11 unmapped addresses have no effect
    wr(13, 32'hFFFF_FFFF);
    wr(14, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    fs();
    chk(cscAfterGamma == 1'b1, "R11", "placement after unmapped", cscAfterGamma, 1);
    pix(300, 20, 40, "R11");
    idle(1);

    // R8 write coinciding with frame start waits one frame
    wrFs(0, {enc(0, 7, 256, 0), 16'h0000});
    pix(300, 20, 40, "R8");
    idle(1);
    fs();
    pix(300, 20, 40, "R8");
    idle(1);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule